// File: doc/BRIEF.md
# Power-Stage Mode Control Register

This block is one 8-bit control register on a simple register bus (address, write data, write strobe, combinational read data). It holds a global enable for every power stage, three shutdown-policy bits (thermal for the high-side devices, thermal for the low-side devices, supply over/under-voltage) and a 2-bit slew-rate select for the bus transmitter. Its outputs go straight to the driver-gating logic. The polarity of each policy bit is "1 = automatic shutdown disabled". The block therefore exposes active-high "automatic shutdown enabled" outputs, so that the reset state is the protected one.

The same register also takes two write-only commands: enter Stop mode and enter Sleep mode. A command is honoured only when every configuration bit in the same write is zero. When it is honoured, the block issues a one-cycle request pulse to the power manager. An interrupt request cancels a command that is pending. The command bits always read back as zero.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the register reads 0x00 and `stagesOn` is 0. `hsThermAuto`, `lsThermAuto` and `voltAuto` are 1, `slewSel` is 0, and `stopReq` and `sleepReq` are 0.
- R2: A read at offset REG_OFFSET returns bit 5 = power-stage enable, bit 4 = low-side thermal disable, bit 3 = high-side thermal disable, bit 2 = voltage shutdown disable, and bits 1:0 = slew select. Bits 7 and 6 always read 0.
- R3: `stagesOn` equals the stored bit 5, one cycle after the write edge.
- R4: `hsThermAuto` is the inverse of bit 3, `lsThermAuto` the inverse of bit 4 and `voltAuto` the inverse of bit 2. `slewSel` equals bits 1:0.
- R5: A write whose data has bit 7 (Stop) or bit 6 (Sleep) set and bits 5:0 all zero gives a pulse on `stopReq` or `sleepReq`. The pulse lasts exactly the one cycle that follows the write edge. Readback then shows 0x00.
- R6: A command write in which any of bits 5:0 is 1 gives no request pulse. Bits 5:0 are still stored as written.
- R7: When bits 7 and 6 are both set in an accepted command, only `stopReq` pulses.
- R8: A high `irqReq` in the write cycle prevents the command from being taken. A high `irqReq` during the pulse cycle suppresses the pulse.
- R9: Writes to any offset other than REG_OFFSET change nothing and give no pulse. Reads from other offsets return 0.
- R10: `stopReq` and `sleepReq` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | 1 | Interrupt request; cancels a pending mode command |
| busAddr | input | ADDR_W | Register offset |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe |
| busRdata | output | 8 | Read data (combinational) |
| stagesOn | output | 1 | Enable for all power stages |
| hsThermAuto | output | 1 | Automatic high-temperature shutdown of high-side devices enabled |
| lsThermAuto | output | 1 | Automatic high-temperature shutdown of low-side devices enabled |
| voltAuto | output | 1 | Automatic low/high-voltage shutdown enabled |
| slewSel | output | 2 | Bus transmitter slew-rate select |
| stopReq | output | 1 | One-cycle Stop mode request |
| sleepReq | output | 1 | One-cycle Sleep mode request |

## Verification
The configuration field is written with complementary patterns (0x25, then 0x1A, then all ones). This shows that each bit lands in its own output with the right polarity and that bits 7:6 never read back. The command bits are tried alone (0x80, 0x40), together (0xC0) and mixed with one configuration bit (0x81). These cases separate acceptance, Stop-over-Sleep priority and rejection. Interrupts are raised in the write cycle and in the pulse cycle, which tells a latched cancel apart from a gated output. Writes to a foreign offset confirm that the address decode blocks both configuration updates and commands.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int REG_W      = 8;
  localparam int CFG_W      = 6;
  localparam int STOP_BIT   = 7;
  localparam int SLEEP_BIT  = 6;
  localparam int PWR_BIT    = 5;
  localparam int LS_DIS_BIT = 4;
  localparam int HS_DIS_BIT = 3;
  localparam int V_DIS_BIT  = 2;
  localparam int SLEW_W     = 2;

  typedef struct packed {
    logic cfgWr;
    logic stopSet;
    logic sleepSet;
  } strobe_t;
endpackage

// File: rtl/pwr_mode_decode.sv
module pwr_mode_decode
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int REG_OFFSET = 0
) (
  input  logic              irqReq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  input  logic              busWe,
  output strobe_t           stb
);
  logic hit;
  logic cfgClear;

  assign hit      = busWe && (busAddr == ADDR_W'(REG_OFFSET));
  assign cfgClear = (busWdata[CFG_W-1:0] == '0);

  always_comb begin
    stb.cfgWr    = hit;
    stb.stopSet  = hit && cfgClear && !irqReq && busWdata[STOP_BIT];
    stb.sleepSet = hit && cfgClear && !irqReq && busWdata[SLEEP_BIT]
                   && !busWdata[STOP_BIT];
  end
endmodule

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             irqReq,
  input  strobe_t          stb,
  input  logic [CFG_W-1:0] wrCfg,
  output logic [CFG_W-1:0] cfgQ,
  output logic             stopReq,
  output logic             sleepReq
);
  logic pendStop;
  logic pendSleep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ      <= '0;
      pendStop  <= 1'b0;
      pendSleep <= 1'b0;
    end else begin
      if (stb.cfgWr) cfgQ <= wrCfg;
      pendStop  <= stb.stopSet;
      pendSleep <= stb.sleepSet;
    end
  end

  assign stopReq  = pendStop && !irqReq;
  assign sleepReq = pendSleep && !irqReq;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int REG_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqReq,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              busWe,
  output logic [7:0]        busRdata,
  output logic              stagesOn,
  output logic              hsThermAuto,
  output logic              lsThermAuto,
  output logic              voltAuto,
  output logic [1:0]        slewSel,
  output logic              stopReq,
  output logic              sleepReq
);
  strobe_t          stb;
  logic [CFG_W-1:0] cfgQ;

  pwr_mode_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
    .irqReq   (irqReq),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busWe    (busWe),
    .stb      (stb)
  );

  pwr_mode_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .irqReq   (irqReq),
    .stb      (stb),
    .wrCfg    (busWdata[CFG_W-1:0]),
    .cfgQ     (cfgQ),
    .stopReq  (stopReq),
    .sleepReq (sleepReq)
  );

  assign busRdata    = (busAddr == ADDR_W'(REG_OFFSET))
                       ? {{(REG_W-CFG_W){1'b0}}, cfgQ} : '0;
  assign stagesOn    = cfgQ[PWR_BIT];
  assign hsThermAuto = ~cfgQ[HS_DIS_BIT];
  assign lsThermAuto = ~cfgQ[LS_DIS_BIT];
  assign voltAuto    = ~cfgQ[V_DIS_BIT];
  assign slewSel     = cfgQ[SLEW_W-1:0];
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int ADDR_W     = 4,
  parameter int REG_OFFSET = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqReq,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWdata,
  input logic              busWe,
  input logic [7:0]        busRdata,
  input logic              stagesOn,
  input logic              hsThermAuto,
  input logic              lsThermAuto,
  input logic              voltAuto,
  input logic [1:0]        slewSel,
  input logic              stopReq,
  input logic              sleepReq
);
  logic hitW;
  assign hitW = busWe && (busAddr == ADDR_W'(REG_OFFSET));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(stopReq && sleepReq));

  a_r5_stop_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !stopReq);

  a_r5_sleep_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> !sleepReq);

  a_r5_stop_cause: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |-> $past(hitW && busWdata[7] && busWdata[5:0] == 6'd0 && !irqReq));

  a_r6_reject: assert property (@(posedge clk) disable iff (!rstN)
    (hitW && busWdata[5:0] != 6'd0) |=> !(stopReq || sleepReq));

  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> !(stopReq || sleepReq));

  a_r2_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[7:6] == 2'b00);

  a_r3_enable_match: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(REG_OFFSET)) |-> (stagesOn == busRdata[5]));

  a_r4_policy_match: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(REG_OFFSET)) |->
      (hsThermAuto == !busRdata[3] && lsThermAuto == !busRdata[4]
       && voltAuto == !busRdata[2] && slewSel == busRdata[1:0]));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_chk (.*);

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              irqReq = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [7:0]        busWdata = '0;
  logic              busWe = 1'b0;
  logic [7:0]        busRdata;
  logic              stagesOn, hsThermAuto, lsThermAuto, voltAuto;
  logic [1:0]        slewSel;
  logic              stopReq, sleepReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.ADDR_W(ADDR_W), .REG_OFFSET(0)) uut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRdata(busRdata),
    .stagesOn(stagesOn), .hsThermAuto(hsThermAuto), .lsThermAuto(lsThermAuto),
    .voltAuto(voltAuto), .slewSel(slewSel), .stopReq(stopReq), .sleepReq(sleepReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // Returns at the falling edge after the write edge (pulse cycle).
  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busAddr = '0;
    #1;
  endtask

  task automatic checkOutputs(input string req, input logic [7:0] cfg);
    check(req, busRdata, {2'b00, cfg[5:0]});
    check(req, {7'd0, stagesOn}, {7'd0, cfg[5]});
    check(req, {7'd0, lsThermAuto}, {7'd0, ~cfg[4]});
    check(req, {7'd0, hsThermAuto}, {7'd0, ~cfg[3]});
    check(req, {7'd0, voltAuto}, {7'd0, ~cfg[2]});
    check(req, {6'd0, slewSel}, {6'd0, cfg[1:0]});
  endtask

  task automatic checkReqs(input string req, input logic s, input logic l);
    check(req, {6'd0, stopReq, sleepReq}, {6'd0, s, l});
  endtask

  task automatic t_reset();
    #1;
    checkOutputs("R1 reset", 8'h00);
    checkReqs("R1 reset", 1'b0, 1'b0);
  endtask

  task automatic t_config();
    busWrite('0, 8'h25);
    checkOutputs("R2 R3 R4 cfg 0x25", 8'h25);
    checkReqs("R6 no pulse on cfg", 1'b0, 1'b0);
    busWrite('0, 8'h1A);
    checkOutputs("R2 R3 R4 cfg 0x1A", 8'h1A);
    busWrite('0, 8'hFF);
    checkReqs("R6 reject 0xFF", 1'b0, 1'b0);
    checkOutputs("R2 R6 top bits zero", 8'h3F);
  endtask

  task automatic t_stop();
    busWrite('0, 8'h80);
    checkReqs("R5 stop pulse", 1'b1, 1'b0);
    check("R5 readback zero", busRdata, 8'h00);
    @(negedge clk); #1;
    checkReqs("R5 stop single cycle", 1'b0, 1'b0);
  endtask

  task automatic t_sleep();
    busWrite('0, 8'h40);
    checkReqs("R5 sleep pulse", 1'b0, 1'b1);
    @(negedge clk); #1;
    checkReqs("R5 sleep single cycle", 1'b0, 1'b0);
  endtask

  task automatic t_both();
    busWrite('0, 8'hC0);
    checkReqs("R7 stop priority", 1'b1, 1'b0);
    @(negedge clk); #1;
    checkReqs("R7 after pulse", 1'b0, 1'b0);
  endtask

  task automatic t_reject();
    busWrite('0, 8'h81);
    checkReqs("R6 stop with slew bit", 1'b0, 1'b0);
    check("R6 cfg stored", busRdata, 8'h01);
    busWrite('0, 8'h60);
    checkReqs("R6 sleep with enable", 1'b0, 1'b0);
    checkOutputs("R6 cfg stored 0x20", 8'h20);
  endtask

  task automatic t_irq();
    @(negedge clk);
    irqReq = 1'b1; busAddr = '0; busWdata = 8'h80; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; irqReq = 1'b0;
    #1;
    checkReqs("R8 irq at write", 1'b0, 1'b0);
    busWrite('0, 8'h40);
    irqReq = 1'b1;
    #1;
    checkReqs("R8 irq in pulse cycle", 1'b0, 1'b0);
    @(negedge clk);
    irqReq = 1'b0;
    #1;
    checkReqs("R8 no late pulse", 1'b0, 1'b0);
  endtask

  task automatic t_addr();
    busWrite('0, 8'h20);
    busWrite(4'd3, 8'h80);
    checkReqs("R9 foreign stop", 1'b0, 1'b0);
    busWrite(4'd3, 8'h15);
    checkOutputs("R9 cfg kept", 8'h20);
    busAddr = 4'd3;
    #1;
    check("R9 foreign read", busRdata, 8'h00);
    busAddr = '0;
    #1;
  endtask

  task automatic t_excl();
    for (int i = 0; i < 4; i++) begin
      busWrite('0, (i[0] ? 8'h80 : 8'h00) | (i[1] ? 8'h40 : 8'h00));
      check("R10 exclusive", {7'd0, stopReq && sleepReq}, 8'h00);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_config();
    t_stop();
    t_sleep();
    t_both();
    t_reject();
    t_irq();
    t_addr();
    t_excl();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule